// File: doc/BRIEF.md
# Digit-Serial Binary Polynomial Multiplier

This block multiplies two binary polynomials of up to 256 coefficients each, with carry-less (XOR) arithmetic. It works one 64-bit slice of the first operand per clock, from the most significant slice down. Each clock it shifts a double-width accumulator left by one slice and XORs in the product of that slice with the whole second operand. The first slice is multiplied in the same cycle that the request is accepted.

There are two modes. In the reducing mode, the accumulated product goes to one of three fixed-polynomial reducers for one more cycle: degree 163, 193 or 233. A field-dependent window selects the product bits that reducer needs. Operands for degree 163 fit in three slices, so the empty top slice is skipped and the run is one cycle shorter. In the non-reducing mode the reducer is bypassed. The full double-width product is then presented as a high word and a low word, for use by software or microcode that reduces by an arbitrary polynomial.

The controller has three states. IDLE waits for `start_i` and, on the accepting edge (transition IDLE→ACCUM), captures the operands and multiplies the first slice. ACCUM consumes one slice per cycle. On the last slice it goes either to REDUCE (reducing mode, ACCUM→REDUCE) or straight back to IDLE with done raised (non-reducing mode, ACCUM→IDLE). REDUCE writes the reduced result, raises done and returns to IDLE (REDUCE→IDLE).

Top module: `gf2_dser_mul`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o`, `prod_hi_o` and `prod_lo_o` are all zero.
- R2: With `mode_i`=1 (non-reducing), `{prod_hi_o, prod_lo_o}` equals the full 512-bit carry-less product X·Y, `prod_hi_o` being bits 511:256 (bit 511 is always 0). `done_o` is high 3 cycles after the accepting edge.
- R3: With `mode_i`=0 and `field_i`=0, `result_o` equals X·Y mod (t^163+t^7+t^6+t^3+1) with bits 255:163 zero, for operands below degree 163. `done_o` is high 3 cycles after the accepting edge.
- R4: With `mode_i`=0 and `field_i`=1, `result_o` equals X·Y mod (t^193+t^15+1), for operands below degree 193. `done_o` is high 4 cycles after the accepting edge.
- R5: With `mode_i`=0 and `field_i`=2, `result_o` equals X·Y mod (t^233+t^74+1), for operands below degree 233, with `done_o` 4 cycles after the accepting edge. `field_i`=3 behaves exactly like `field_i`=2.
- R6: In reducing mode, `{prod_hi_o, prod_lo_o}` also holds the unreduced product X·Y when `done_o` is high.
- R7: `done_o` is high for exactly one cycle per accepted request.
- R8: `result_o`, `prod_hi_o` and `prod_lo_o` keep their values while the block is idle and no start is given.
- R9: `start_i` asserted while a request is in progress is ignored: the running request completes with its own operands and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted only when idle |
| mode_i | input | 1 | 0 = reduce by a fixed field polynomial, 1 = return unreduced product |
| field_i | input | 2 | Field code: 0 = degree 163, 1 = 193, 2 and 3 = 233 |
| x_i | input | 256 | First operand, consumed one 64-bit slice per cycle |
| y_i | input | 256 | Second operand |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 256 | Reduced field element, zero-extended |
| prod_hi_o | output | 256 | Upper half of the double-width product |
| prod_lo_o | output | 256 | Lower half of the double-width product |

## Verification
Operands with the top coefficient of every slice set and all-ones operands go after shift or slice-ordering errors. A design that consumed slices in the wrong order or shifted by the wrong amount would scramble the high product word. Squaring t^(m−1) for each field yields the highest-degree product the reducer must fold; a reducer with too narrow a window or a missing fold pass would leave bits at or above m. The short degree-163 run, field code 3, and a start held high into a busy cycle target latency mistakes and wrongly re-captured operands, which show up as a done pulse in the wrong cycle or a result built from the second operand set.

// File: rtl/gf2m_mul_pkg.sv
package gf2m_mul_pkg;

    localparam int N_FIELDS = 3;
    localparam int TAP_W    = 256;

    typedef enum logic [1:0] {
        FLD_163 = 2'd0,
        FLD_193 = 2'd1,
        FLD_233 = 2'd2,
        FLD_ALT = 2'd3
    } field_e;

    typedef enum logic {
        OP_MUL   = 1'b0,
        OP_MULNR = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_REDUCE = 2'd2
    } state_e;

    // Degree of each hardwired field polynomial, indexed by field code.
    localparam int FIELD_DEG [N_FIELDS] = '{163, 193, 233};

    // Low-order terms of each field polynomial (the polynomial minus its leading term).
    localparam logic [TAP_W-1:0] FIELD_TAPS [N_FIELDS] = '{
        (TAP_W'(1) << 7) | (TAP_W'(1) << 6) | (TAP_W'(1) << 3) | TAP_W'(1),
        (TAP_W'(1) << 15) | TAP_W'(1),
        (TAP_W'(1) << 74) | TAP_W'(1)
    };

endpackage

// File: rtl/gf2_digit_clmul.sv
module gf2_digit_clmul #(
    parameter int DIG_W = 64,
    parameter int OP_W  = 256,
    localparam int PP_W = DIG_W + OP_W - 1
) (
    input  logic [DIG_W-1:0] dig_i,
    input  logic [OP_W-1:0]  opd_i,
    output logic [PP_W-1:0]  pp_o
);

    // One shifted copy of the full operand per set coefficient of the slice.
    logic [PP_W-1:0] term [DIG_W];

    for (genvar k = 0; k < DIG_W; k++) begin : g_term
        assign term[k] = dig_i[k] ? (PP_W'(opd_i) << k) : '0;
    end

    always_comb begin
        pp_o = '0;
        for (int k = 0; k < DIG_W; k++) begin
            pp_o = pp_o ^ term[k];
        end
    end

endmodule

// File: rtl/gf2_fixed_reducer.sv
module gf2_fixed_reducer #(
    parameter int OP_W = 256,
    parameter int M_DEG = 163,
    parameter logic [gf2m_mul_pkg::TAP_W-1:0] TAPS = '0,
    localparam int PROD_W = 2 * OP_W,
    localparam int WIN_W  = 2 * M_DEG - 1
) (
    input  logic [PROD_W-1:0] prod_i,
    output logic [OP_W-1:0]   res_o
);

    // Window of the accumulator that a product of two degree < M_DEG operands can occupy.
    localparam logic [PROD_W-1:0] WIN_MASK = (PROD_W'(1) << WIN_W) - PROD_W'(1);

    logic [PROD_W-1:0] fold;

    always_comb begin
        fold = prod_i & WIN_MASK;
        for (int i = WIN_W - 1; i >= M_DEG; i--) begin
            if (fold[i]) begin
                fold[i] = 1'b0;
                fold    = fold ^ (PROD_W'(TAPS) << (i - M_DEG));
            end
        end
        res_o = '0;
        res_o[M_DEG-1:0] = fold[M_DEG-1:0];
    end

endmodule

// File: rtl/gf2_dser_mul.sv
module gf2_dser_mul
    import gf2m_mul_pkg::*;
#(
    parameter int OP_W  = 256,
    parameter int DIG_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            mode_i,
    input  logic [1:0]      field_i,
    input  logic [OP_W-1:0] x_i,
    input  logic [OP_W-1:0] y_i,
    output logic            done_o,
    output logic [OP_W-1:0] result_o,
    output logic [OP_W-1:0] prod_hi_o,
    output logic [OP_W-1:0] prod_lo_o
);

    localparam int NDIG      = OP_W / DIG_W;
    localparam int IDX_W     = $clog2(NDIG);
    localparam int PROD_W    = 2 * OP_W;
    localparam int PP_W      = DIG_W + OP_W - 1;
    localparam int SHORT_DIG = (FIELD_DEG[0] + DIG_W - 1) / DIG_W;
    localparam logic [IDX_W-1:0] FULL_FIRST  = IDX_W'(NDIG - 1);
    localparam logic [IDX_W-1:0] SHORT_FIRST = IDX_W'(SHORT_DIG - 1);

    state_e              state_q, state_d;
    logic [IDX_W-1:0]    dig_q;
    logic [OP_W-1:0]     x_q, y_q;
    op_e                 mode_q;
    field_e              field_q;
    logic [PROD_W-1:0]   acc_q;
    logic                done_q;
    logic [OP_W-1:0]     res_q;

    logic                accept;
    logic                last_dig;
    logic [IDX_W-1:0]    first_idx;
    logic [DIG_W-1:0]    cur_dig;
    logic [OP_W-1:0]     cur_opd;
    logic [PP_W-1:0]     pp;
    logic [OP_W-1:0]     red_out [N_FIELDS];
    logic [OP_W-1:0]     red_sel;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_dig  = (state_q == ST_ACCUM) && (dig_q == '0);
    assign first_idx = ((op_e'(mode_i) == OP_MUL) && (field_e'(field_i) == FLD_163))
                       ? SHORT_FIRST : FULL_FIRST;

    // First slice comes straight from the inputs on the accepting edge.
    always_comb begin
        if (state_q == ST_IDLE) begin
            cur_dig = x_i[first_idx*DIG_W +: DIG_W];
            cur_opd = y_i;
        end else begin
            cur_dig = x_q[dig_q*DIG_W +: DIG_W];
            cur_opd = y_q;
        end
    end

    gf2_digit_clmul #(
        .DIG_W(DIG_W),
        .OP_W (OP_W)
    ) u_clmul (
        .dig_i(cur_dig),
        .opd_i(cur_opd),
        .pp_o (pp)
    );

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_red
        gf2_fixed_reducer #(
            .OP_W (OP_W),
            .M_DEG(FIELD_DEG[g]),
            .TAPS (FIELD_TAPS[g])
        ) u_red (
            .prod_i(acc_q),
            .res_o (red_out[g])
        );
    end

    always_comb begin
        unique case (field_q)
            FLD_163: red_sel = red_out[0];
            FLD_193: red_sel = red_out[1];
            FLD_233: red_sel = red_out[2];
            FLD_ALT: red_sel = red_out[2];
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ACCUM;
            ST_ACCUM:  if (dig_q == '0) state_d = (mode_q == OP_MULNR) ? ST_IDLE : ST_REDUCE;
            ST_REDUCE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Operand capture, slice counter and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_q   <= '0;
            x_q     <= '0;
            y_q     <= '0;
            mode_q  <= OP_MUL;
            field_q <= FLD_163;
            acc_q   <= '0;
        end else if (accept) begin
            dig_q   <= first_idx - IDX_W'(1);
            x_q     <= x_i;
            y_q     <= y_i;
            mode_q  <= op_e'(mode_i);
            field_q <= field_e'(field_i);
            acc_q   <= PROD_W'(pp);
        end else if (state_q == ST_ACCUM) begin
            acc_q <= (acc_q << DIG_W) ^ PROD_W'(pp);
            if (dig_q != '0) dig_q <= dig_q - IDX_W'(1);
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= (last_dig && (mode_q == OP_MULNR)) || (state_q == ST_REDUCE);
            if (state_q == ST_REDUCE) res_q <= red_sel;
        end
    end

    assign done_o    = done_q;
    assign result_o  = res_q;
    assign prod_hi_o = acc_q[PROD_W-1:OP_W];
    assign prod_lo_o = acc_q[OP_W-1:0];

    // Cycles since the accepting edge, used only by the checks below.
    logic [3:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    lat_q <= '0;
        else if (accept)               lat_q <= '0;
        else if (state_q != ST_IDLE)   lat_q <= lat_q + 4'd1;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2
    nr_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && mode_q == OP_MULNR) |-> (lat_q == 4'(NDIG - 1)));

    // R3
    short_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && mode_q == OP_MUL && field_q == FLD_163) |-> (lat_q == 4'(SHORT_DIG)));

    // R4
    full_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && mode_q == OP_MUL && field_q != FLD_163) |-> (lat_q == 4'(NDIG)));

    // R3
    red163_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && mode_q == OP_MUL && field_q == FLD_163) |-> ((res_q >> FIELD_DEG[0]) == '0));

    // R2
    prod_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !acc_q[PROD_W-1]);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> ($stable(res_q) && $stable(acc_q)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(y_q) && $stable(x_q) && $stable(mode_q)));

endmodule

// File: tb/gf2_dser_mul_tb.sv
module gf2_dser_mul_tb_top;

    localparam int OP_W = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            mode_i = 1'b0;
    logic [1:0]      field_i = 2'd0;
    logic [OP_W-1:0] x_i = '0;
    logic [OP_W-1:0] y_i = '0;
    logic            done_o;
    logic [OP_W-1:0] result_o, prod_hi_o, prod_lo_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gf2_dser_mul #(.OP_W(OP_W), .DIG_W(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .field_i(field_i), .x_i(x_i), .y_i(y_i), .done_o(done_o),
        .result_o(result_o), .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o)
    );

    function automatic logic [2*OP_W-1:0] ref_clmul(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
        logic [2*OP_W-1:0] p = '0;
        for (int i = 0; i < OP_W; i++)
            if (b[i]) p = p ^ ({{OP_W{1'b0}}, a} << i);
        return p;
    endfunction

    function automatic int ref_deg(int code);
        return (code == 0) ? 163 : (code == 1) ? 193 : 233;
    endfunction

    function automatic logic [2*OP_W-1:0] ref_poly(int code);
        logic [2*OP_W-1:0] m = (2*OP_W)'(1) << ref_deg(code);
        if (code == 0) m = m | (1 << 7) | (1 << 6) | (1 << 3) | 1;
        else if (code == 1) m = m | (1 << 15) | 1;
        else m = m | ((2*OP_W)'(1) << 74) | 1;
        return m;
    endfunction

    function automatic logic [OP_W-1:0] ref_mod(logic [2*OP_W-1:0] p, int code);
        int d = ref_deg(code);
        for (int i = 2*OP_W-1; i >= d; i--)
            if (p[i]) p = p ^ (ref_poly(code) << (i - d));
        return p[OP_W-1:0];
    endfunction

    function automatic logic [OP_W-1:0] rnd_op();
        logic [OP_W-1:0] v;
        for (int i = 0; i < OP_W/32; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, logic [OP_W-1:0] act, logic [OP_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one request; optional second start with other operands while busy.
    task automatic run_op(bit mode, int code, logic [OP_W-1:0] x, logic [OP_W-1:0] y,
                          bit busy_start, string req);
        logic [2*OP_W-1:0] full;
        logic [OP_W-1:0]   red;
        int exp_lat, lat;
        full = ref_clmul(x, y);
        red  = ref_mod(full, code);
        exp_lat = mode ? 3 : (code == 0 ? 3 : 4);
        @(negedge clk);
        start_i = 1'b1; mode_i = mode; field_i = 2'(code); x_i = x; y_i = y;
        @(negedge clk);
        if (busy_start) begin
            mode_i = ~mode; field_i = 2'(3 - code); x_i = ~x; y_i = ~y;
        end else begin
            start_i = 1'b0;
        end
        lat = 0;
        while (lat < 12) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
            if (done_o) break;
        end
        check(done_o && lat == exp_lat, req, "latency", OP_W'(lat), OP_W'(exp_lat));
        if (mode) begin
            check(prod_hi_o == full[2*OP_W-1:OP_W], req, "hi word", prod_hi_o, full[2*OP_W-1:OP_W]);
            check(prod_lo_o == full[OP_W-1:0], req, "lo word", prod_lo_o, full[OP_W-1:0]);
        end else begin
            check(result_o == red, req, "reduced", result_o, red);
            // R6 unreduced product also visible in reducing mode
            check({prod_hi_o, prod_lo_o} == full, "R6", "unreduced lo", prod_lo_o, full[OP_W-1:0]);
        end
        @(negedge clk);
        // R7
        check(!done_o, "R7", "done width", OP_W'(done_o), '0);
        @(negedge clk);
        // R8
        check(prod_lo_o == full[OP_W-1:0] && prod_hi_o == full[2*OP_W-1:OP_W]
              && (mode || result_o == red), "R8", "hold", prod_lo_o, full[OP_W-1:0]);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check(!done_o && result_o == '0 && prod_hi_o == '0 && prod_lo_o == '0,
              "R1", "reset state", result_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        run_op(1'b1, 0, '1, '1, 1'b0, "R2");
        run_op(1'b1, 0, {4{64'h8000_0000_0000_0000}}, {4{64'h8000_0000_0000_0001}}, 1'b0, "R2");
        run_op(1'b1, 0, '0, rnd_op(), 1'b0, "R2");
        for (int c = 0; c < 4; c++) begin
            logic [OP_W-1:0] top = OP_W'(1) << (ref_deg(c) - 1);
            run_op(1'b0, c, top, top, 1'b0, c == 0 ? "R3" : c == 1 ? "R4" : "R5");
        end
        run_op(1'b0, 2, (OP_W'(1) << 233) - 1, (OP_W'(1) << 233) - 1, 1'b0, "R5");
        run_op(1'b0, 3, (OP_W'(1) << 233) - 1, OP_W'(3), 1'b0, "R5");
        // R9 start held into the busy cycle with different operands
        run_op(1'b0, 0, rnd_op() & ((OP_W'(1) << 163) - 1),
               rnd_op() & ((OP_W'(1) << 163) - 1), 1'b1, "R9");
        run_op(1'b1, 1, rnd_op(), rnd_op(), 1'b1, "R9");

        // Constrained random
        for (int n = 0; n < 60; n++) begin
            int c = int'($urandom_range(0, 3));
            bit md = 1'(($urandom() >> 3) & 1);
            logic [OP_W-1:0] msk = md ? '1 : ((OP_W'(1) << ref_deg(c)) - 1);
            run_op(md, c, rnd_op() & msk, rnd_op() & msk, 1'b0,
                   md ? "R2" : c == 0 ? "R3" : c == 1 ? "R4" : "R5");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule